// File: doc/BRIEF.md
# Addressable Cascadable Shift Register

This block is a serial-in delay line of 128 bits made from eight identical 16-bit segments. Each segment shifts one new bit in on every rising clock edge that has the clock enable high. A dedicated cascade path carries the last bit of each segment into the first bit of the next. That path is separate from the addressed read, so the chain never depends on the tap address. The storage has no set or reset, and its contents stay undefined until enough bits have been shifted in.

A 7-bit tap address selects any of the 128 positions. Its upper bits pick a segment through a tree of 2:1 multiplexers, and its lower bits pick the position inside that segment. The selected bit appears on an asynchronous tap output. An optional output flip-flop gives a synchronous read of the same tap. With a constant address it acts as one extra stage of the delay line. The last bit of the final segment is brought out as a cascade output, so further lines can be chained behind this one.

Top module: `acsr_chain`

## Requirements
- R1: On each rising clock edge with `ce` high, the bit on `din` enters position 0 and every stored bit moves from position p to position p+1, across segment boundaries as well.
- R2: With `tap_addr` = k (0 to 127), `tap_q` shows combinationally the bit shifted in k enabled edges earlier; address 0 is the newest bit. Bits [6:4] of the address pick the segment and bits [3:0] pick the position inside it.
- R3: `casc_out` always carries position 127, the bit shifted in 127 enabled edges earlier, whatever the value of `tap_addr`.
- R4: While `ce` is low, clock edges change neither the stored bits nor `casc_out`. `tap_q` still follows changes of `tap_addr`.
- R5: `tap_q_reg` loads the value `tap_q` had just before an enabled rising edge, and holds on edges where `ce` is low.
- R6: With the address held at a constant N, a bit presented on `din` appears on `tap_q_reg` after exactly N+2 enabled edges, counting the edge that takes it in.
- R7: `rst_n` low clears `tap_q_reg` to 0 at once and holds it there. The shift storage, `tap_q` and `casc_out` keep their values through the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the storage shifts on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the output flip-flop only |
| ce | input | 1 | Clock enable for shifting and for the output flip-flop |
| din | input | 1 | Serial data into position 0 |
| tap_addr | input | 7 | Tap position to read (0 = newest bit) |
| tap_q | output | 1 | Asynchronous tap read |
| tap_q_reg | output | 1 | Registered tap read |
| casc_out | output | 1 | Last bit of the final segment (position 127) |

## Verification
The bench builds the block with its default parameters: eight segments of sixteen bits, with the output flip-flop present. At this depth the whole 128-bit history can be modelled arithmetically in the bench. The bench can then sweep every tap address after every shift, with both enabled and stalled edges, and compare all 128 positions together with the cascade bit. Because the line is short, the bench can also flush it completely with zeros and follow a single pulse to measure the N+2 delay of the registered path.

// File: rtl/acsr_pkg.sv
package acsr_pkg;

  // Default geometry of the line.
  localparam int unsigned ACSR_SEG_DEPTH_DEF = 16;
  localparam int unsigned ACSR_NUM_SEGS_DEF  = 8;

  // Width of an index that selects one of n items (at least 1).
  function automatic int unsigned acsr_idx_w(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/acsr_seg.sv
// One 16-deep (parameterised) shift segment with addressable tap and a
// fixed last-bit cascade output. The storage has no reset by intent.
module acsr_seg #(
  parameter int unsigned DEPTH = acsr_pkg::ACSR_SEG_DEPTH_DEF,
  localparam int unsigned AW   = acsr_pkg::acsr_idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          sin,
  input  logic [AW-1:0] addr,
  output logic          tap,
  output logic          casc
);

  logic [DEPTH-1:0] store_q;
  logic [DEPTH-1:0] store_d;

  // Next state: new bit enters at position 0, older bits move up.
  always_comb begin
    store_d = {store_q[DEPTH-2:0], sin};
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      store_q <= store_d;
    end
  end

  // Asynchronous read of the addressed position.
  always_comb begin
    tap = store_q[addr];
  end

  // Dedicated path from the last position, independent of addr.
  assign casc = store_q[DEPTH-1];

endmodule

// File: rtl/acsr_tap_tree.sv
// Tree of 2:1 multiplexers that picks one segment tap; stage s
// combines neighbouring pairs using select bit s-1.
module acsr_tap_tree #(
  parameter int unsigned N  = acsr_pkg::ACSR_NUM_SEGS_DEF,
  localparam int unsigned SW = acsr_pkg::acsr_idx_w(N)
) (
  input  logic [N-1:0]  leaves,
  input  logic [SW-1:0] sel,
  output logic          out
);

  for (genvar s = 0; s <= SW; s++) begin : stage_g
    localparam int unsigned WIDTH = N >> s;
    logic [WIDTH-1:0] v;
    if (s == 0) begin : leaf_g
      assign v = leaves;
    end else begin : mux_g
      for (genvar j = 0; j < WIDTH; j++) begin : pair_g
        assign v[j] = sel[s-1] ? stage_g[s-1].v[2*j+1] : stage_g[s-1].v[2*j];
      end
    end
  end

  assign out = stage_g[SW].v[0];

endmodule

// File: rtl/acsr_tap_reg.sv
// Output flip-flop for a synchronous tap read; reset touches only it.
module acsr_tap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic d,
  output logic q
);

  logic q_d;

  always_comb begin
    q_d = ce ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/acsr_chain.sv
// Chain of shift segments joined through their cascade paths, with a
// wide tap address selecting any position of the whole line.
module acsr_chain #(
  parameter int unsigned SEG_DEPTH   = acsr_pkg::ACSR_SEG_DEPTH_DEF,
  parameter int unsigned NUM_SEGS    = acsr_pkg::ACSR_NUM_SEGS_DEF,
  parameter bit          USE_OUT_REG = 1'b1,
  localparam int unsigned POS_W  = acsr_pkg::acsr_idx_w(SEG_DEPTH),
  localparam int unsigned SEG_W  = acsr_pkg::acsr_idx_w(NUM_SEGS),
  localparam int unsigned ADDR_W = POS_W + SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              din,
  input  logic [ADDR_W-1:0] tap_addr,
  output logic              tap_q,
  output logic              tap_q_reg,
  output logic              casc_out
);

  logic [NUM_SEGS-1:0] seg_sin;
  logic [NUM_SEGS-1:0] seg_tap;
  logic [NUM_SEGS-1:0] seg_casc;
  logic [POS_W-1:0]    pos_sel;
  logic [SEG_W-1:0]    seg_sel;

  assign pos_sel = tap_addr[POS_W-1:0];
  assign seg_sel = tap_addr[ADDR_W-1:POS_W];

  for (genvar k = 0; k < NUM_SEGS; k++) begin : seg_g
    if (k == 0) begin : head_g
      assign seg_sin[k] = din;
    end else begin : link_g
      assign seg_sin[k] = seg_casc[k-1];
    end

    acsr_seg #(
      .DEPTH (SEG_DEPTH)
    ) seg_i (
      .clk  (clk),
      .ce   (ce),
      .sin  (seg_sin[k]),
      .addr (pos_sel),
      .tap  (seg_tap[k]),
      .casc (seg_casc[k])
    );
  end

  acsr_tap_tree #(
    .N (NUM_SEGS)
  ) tree_i (
    .leaves (seg_tap),
    .sel    (seg_sel),
    .out    (tap_q)
  );

  assign casc_out = seg_casc[NUM_SEGS-1];

  if (USE_OUT_REG) begin : oreg_g
    acsr_tap_reg reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce),
      .d     (tap_q),
      .q     (tap_q_reg)
    );
  end else begin : bypass_g
    assign tap_q_reg = tap_q;
  end

endmodule

// File: rtl/acsr_chain_chk.sv
module acsr_chain_chk #(
  parameter int unsigned SEG_DEPTH   = 16,
  parameter int unsigned NUM_SEGS    = 8,
  parameter bit          USE_OUT_REG = 1'b1,
  localparam int unsigned TOTAL  = SEG_DEPTH * NUM_SEGS,
  localparam int unsigned ADDR_W = acsr_pkg::acsr_idx_w(SEG_DEPTH)
                                 + acsr_pkg::acsr_idx_w(NUM_SEGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              din,
  input logic [ADDR_W-1:0] tap_addr,
  input logic              tap_q,
  input logic              tap_q_reg,
  input logic              casc_out
);

  // R1/R2: newest position returns the bit taken in at the last enabled edge.
  a_r2_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ce ##1 (tap_addr == '0) |-> tap_q == $past(din));

  // R3: the bit seen at the next-to-last tap moves onto the cascade output.
  a_r3_cascade_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && tap_addr == ADDR_W'(TOTAL - 2)) |=> casc_out == $past(tap_q));

  // R4: stalled edges leave the cascade output alone.
  a_r4_casc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(casc_out));

  if (USE_OUT_REG) begin : oreg_chk_g
    // R5: registered tap captures the asynchronous tap on enabled edges.
    a_r5_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> tap_q_reg == $past(tap_q));

    // R5: registered tap holds on stalled edges.
    a_r5_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(tap_q_reg));

    // R7: reset keeps the output flip-flop cleared.
    a_r7_reset_clears: assert property (@(posedge clk)
      !rst_n |-> tap_q_reg == 1'b0);
  end

endmodule

bind acsr_chain acsr_chain_chk #(
  .SEG_DEPTH   (SEG_DEPTH),
  .NUM_SEGS    (NUM_SEGS),
  .USE_OUT_REG (USE_OUT_REG)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce        (ce),
  .din       (din),
  .tap_addr  (tap_addr),
  .tap_q     (tap_q),
  .tap_q_reg (tap_q_reg),
  .casc_out  (casc_out)
);

// File: tb/acsr_chain_tb_top.sv
`timescale 1ns/1ps
module acsr_chain_tb_top;

  localparam int TOTAL = 128;
  localparam int AW    = 7;
  localparam int NDL   = 20;

  logic          clk;
  logic          rst_n;
  logic          ce;
  logic          din;
  logic [AW-1:0] tap_addr;
  logic          tap_q;
  logic          tap_q_reg;
  logic          casc_out;

  int            n_checks;
  int            n_errors;
  bit            finished;
  logic [255:0]  hist;     // bit 0 = newest bit shifted in
  int            nsh;
  logic [15:0]   lfsr;

  acsr_chain dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .din       (din),
    .tap_addr  (tap_addr),
    .tap_q     (tap_q),
    .tap_q_reg (tap_q_reg),
    .casc_out  (casc_out)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not end (actual=hung expected=done)");
    summary();
  end

  task automatic chk(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b (addr=%0d shifts=%0d)",
               req, got, exp, tap_addr, nsh);
    end
  endtask

  // Drive one clock cycle; sample afterwards, away from the edge.
  task automatic tick(input logic b, input logic en);
    @(negedge clk);
    din = b;
    ce  = en;
    @(posedge clk);
    #1;
    if (en) begin
      hist = {hist[254:0], b};
      nsh++;
    end
    ce = 1'b0;
  endtask

  function automatic logic next_bit();
    logic b;
    b = lfsr[0];
    lfsr = {1'b0, lfsr[15:1]} ^ (b ? 16'hB400 : 16'h0000);
    return b;
  endfunction

  // Read every address combinationally and compare with the history.
  task automatic sweep(input string req);
    for (int a = 0; a < TOTAL; a++) begin
      tap_addr = AW'(a);
      #1;
      if (a < nsh) chk(req, tap_q, hist[a]);
      if (nsh >= TOTAL) chk("R3 cascade independent of address", casc_out, hist[TOTAL-1]);
    end
  endtask

  initial begin
    logic cb;
    logic rb;
    int   edges;
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    hist     = '0;
    nsh      = 0;
    lfsr     = 16'hACE1;
    ce       = 1'b0;
    din      = 1'b0;
    tap_addr = '0;
    rst_n    = 1'b1;
    #1 rst_n = 1'b0;

    // R7: reset state of the output flip-flop.
    repeat (3) @(posedge clk);
    #1 chk("R7 reset clears tap_q_reg", tap_q_reg, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R5: fill the line; address 5 fixed, registered tap tracks it.
    tap_addr = AW'(5);
    for (int i = 0; i < 160; i++) begin
      tick(next_bit(), 1'b1);
      if (nsh >= 7) chk("R5 tap_q_reg captures tap on enabled edge", tap_q_reg, hist[6]);
      tap_addr = '0;
      #1 chk("R1 newest bit at position 0", tap_q, hist[0]);
      tap_addr = AW'(5);
    end

    // R2/R3/R4: mixed enabled and stalled edges, full address sweep each.
    for (int i = 0; i < 40; i++) begin
      logic en;
      en = (i % 3) != 0;
      tap_addr = AW'((i * 37) % TOTAL);
      #1;
      cb = casc_out;
      rb = tap_q_reg;
      tick(next_bit(), en);
      if (!en) begin
        chk("R4 cascade holds while ce low", casc_out, cb);
        chk("R5 tap_q_reg holds while ce low", tap_q_reg, rb);
        sweep("R4 storage holds and tap follows address while ce low");
      end else begin
        sweep("R2 tap address selects bit k shifts ago");
      end
    end

    // R6: flush with zeros, send one pulse, measure registered delay.
    tap_addr = AW'(NDL);
    for (int i = 0; i < TOTAL + 4; i++) tick(1'b0, 1'b1);
    chk("R6 line flushed before pulse", tap_q_reg, 1'b0);
    tick(1'b1, 1'b1);
    edges = 1;
    while (tap_q_reg !== 1'b1 && edges < 200) begin
      tick(1'b0, 1'b1);
      edges++;
    end
    n_checks++;
    if (edges != NDL + 2) begin
      n_errors++;
      $display("FAIL R6 delay with constant address: actual=%0d expected=%0d",
               edges, NDL + 2);
    end

    // R7: reset in mid-run clears only the output flip-flop.
    chk("R7 tap_q_reg set before reset", tap_q_reg, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7 reset clears tap_q_reg at once", tap_q_reg, 1'b0);
    chk("R7 tap_q unaffected by reset", tap_q, hist[NDL]);
    sweep("R7 storage unaffected by reset");
    @(negedge clk);
    rst_n = 1'b1;
    tap_addr = AW'(3);
    tick(1'b1, 1'b1);
    chk("R5 tap_q_reg loads after reset release", tap_q_reg, hist[4]);

    summary();
  end

endmodule